// File: doc/BRIEF.md
# Lifecycle Wipe Request Arbiter

This block sits in front of a single flash operation engine and decides who may use it: a software command port or a hardware wipe-request port. Software submits one operation at a time (read, program or erase of a page). The block grants it, forwards the command to the engine over a valid/ready command channel, and returns the engine's completion and error status.

A wipe request may arrive at any moment, including the first cycle after reset. The block lets any software operation already granted run to completion. It then takes the engine and walks pages 0 to WIPE_PAGES-1. For each page it issues an erase, then a program, then a verify read. It moves on only when the engine reports each step done without error. A clean finish pulses the acknowledge once. An engine error during any wipe step moves the sequencer to an invalid state and raises a sticky fatal flag instead.

Either ending is terminal until reset. From then on software requests are never granted and never reach the engine. Reset is asynchronous and active low, and it clears every piece of state, so the next operation starts clean.

Top module: `wipe_arb`

## Requirements
- R1: While and after reset, sw_gnt, sw_done, wipe_ack, wipe_busy, fatal_err and eng_cmd_valid are all low.
- R2: When sw_req is high at a clock edge, no software operation is active, the sequencer is idle and wipe_req is low, sw_gnt is high for exactly the next cycle. In that same cycle eng_cmd_valid is high and carries the sampled sw_op and sw_page.
- R3: Back-pressure: once eng_cmd_valid is high it stays high, with eng_op and eng_page unchanged, until the cycle in which eng_cmd_ready is high. The command transfers in that cycle.
- R4: While a software operation owns the engine, sw_done is high in exactly the cycles where eng_done is high, and sw_err then equals eng_err.
- R5: A wipe request that arrives while a software operation is outstanding issues no wipe command before that operation's sw_done.
- R6: The wipe issues, for page 0 up to WIPE_PAGES-1 in order, the op codes erase (2), program (1) and read (0). Op code 3 is never issued. Each command is issued only after the previous one returned done without error.
- R7: After the last verify completes without error, wipe_ack is high for exactly one cycle. wipe_busy is high while wipe commands are being sequenced and low after the acknowledge.
- R8: Once the wipe has ended, cleanly or not, sw_req is never granted and eng_cmd_valid stays low until reset.
- R9: An engine error on any wipe step raises fatal_err, which stays high until reset. No further command is issued, and wipe_ack never asserts.
- R10: A wipe request is honoured in any cycle, including the first cycle after reset. When sw_req and wipe_req are both high at the same edge, software is not granted.
- R11: A reset in the middle of a wipe returns every output to its reset value. A following software operation and a following wipe then behave as from power-up.
- R12: wipe_req may be a single-cycle pulse. The request is remembered until the wipe runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software operation request (level) |
| sw_op | input | 2 | Software op code: 0 read, 1 program, 2 erase |
| sw_page | input | PAGE_W | Software target page |
| sw_gnt | output | 1 | One-cycle grant of the software request |
| sw_done | output | 1 | Software operation completed |
| sw_err | output | 1 | Engine error for the completed software operation |
| wipe_req | input | 1 | Hardware wipe request (pulse or level) |
| wipe_ack | output | 1 | One-cycle acknowledge of a clean wipe |
| wipe_busy | output | 1 | Wipe sequencer owns the engine |
| fatal_err | output | 1 | Sticky error raised by a failed wipe step |
| eng_cmd_valid | output | 1 | Engine command valid |
| eng_cmd_ready | input | 1 | Engine command ready |
| eng_op | output | 2 | Engine op code |
| eng_page | output | PAGE_W | Engine target page |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error, qualified by eng_done |

## Verification
The bench builds the block with TOTAL_PAGES=8 and WIPE_PAGES=3, so a full wipe takes nine engine commands. With that size the page-advance branch, the last-page branch and an error injected mid-way on page 1 are all reached in a few hundred cycles. Its engine stub has per-operation latency and a ready stall, which exercises hold-under-back-pressure on both software and wipe commands. Because pages 6 and 7 lie outside the wipe range, software traffic there shows that the page field is passed through at full width.

// File: rtl/wipe_arb_pkg.sv
package wipe_arb_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } eng_op_e;

  // Order matters: PAGE_SEL .. INVALID form the in-progress/terminal range.
  typedef enum logic [2:0] {
    W_IDLE     = 3'd0,
    W_DRAIN    = 3'd1,
    W_PAGE_SEL = 3'd2,
    W_ERASE    = 3'd3,
    W_PROG     = 3'd4,
    W_VERIFY   = 3'd5,
    W_FINAL    = 3'd6,
    W_INVALID  = 3'd7
  } wipe_st_e;

  function automatic logic owns_engine(wipe_st_e s);
    return (s == W_PAGE_SEL) || (s == W_ERASE) || (s == W_PROG) || (s == W_VERIFY);
  endfunction

  function automatic logic is_step(wipe_st_e s);
    return (s == W_ERASE) || (s == W_PROG) || (s == W_VERIFY);
  endfunction

endpackage

// File: rtl/wipe_arb_sw.sv
module wipe_arb_sw #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [1:0]        sw_op,
  input  logic [PAGE_W-1:0] sw_page,
  input  logic              allow,
  input  logic              cmd_ready,
  input  logic              done,
  output logic              gnt,
  output logic              busy,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [PAGE_W-1:0] cmd_page
);

  logic              busy_q;
  logic              issued_q;
  logic              gnt_q;
  logic [1:0]        op_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      issued_q <= 1'b0;
      gnt_q    <= 1'b0;
      op_q     <= '0;
      page_q   <= '0;
    end else begin
      gnt_q <= 1'b0;
      if (!busy_q) begin
        if (sw_req && allow) begin
          busy_q   <= 1'b1;
          issued_q <= 1'b0;
          gnt_q    <= 1'b1;
          op_q     <= sw_op;
          page_q   <= sw_page;
        end
      end else begin
        if (!issued_q && cmd_ready) begin
          issued_q <= 1'b1;
        end
        if (issued_q && done) begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign gnt       = gnt_q;
  assign busy      = busy_q;
  assign cmd_valid = busy_q && !issued_q;
  assign cmd_op    = op_q;
  assign cmd_page  = page_q;

endmodule

// File: rtl/wipe_arb_seq.sv
module wipe_arb_seq
  import wipe_arb_pkg::*;
#(
  parameter int WIPE_PAGES = 4,
  parameter int PAGE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe_req,
  input  logic              sw_busy,
  input  logic              cmd_ready,
  input  logic              done,
  input  logic              err,
  output logic              sw_allow,
  output logic              owns,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              ack,
  output logic              fatal
);

  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(WIPE_PAGES - 1);

  wipe_st_e          st_q;
  logic [PAGE_W-1:0] page_q;
  logic              issued_q;
  logic              ack_q;
  logic              fatal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= W_IDLE;
      page_q   <= '0;
      issued_q <= 1'b0;
      ack_q    <= 1'b0;
      fatal_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        W_IDLE: begin
          if (wipe_req) begin
            st_q   <= W_DRAIN;
            page_q <= '0;
          end
        end
        W_DRAIN: begin
          if (!sw_busy) st_q <= W_PAGE_SEL;
        end
        W_PAGE_SEL: begin
          issued_q <= 1'b0;
          st_q     <= W_ERASE;
        end
        W_ERASE, W_PROG, W_VERIFY: begin
          if (!issued_q) begin
            if (cmd_ready) issued_q <= 1'b1;
          end else if (done) begin
            issued_q <= 1'b0;
            if (err) begin
              st_q    <= W_INVALID;
              fatal_q <= 1'b1;
            end else if (st_q == W_ERASE) begin
              st_q <= W_PROG;
            end else if (st_q == W_PROG) begin
              st_q <= W_VERIFY;
            end else if (page_q == LAST_PAGE) begin
              st_q  <= W_FINAL;
              ack_q <= 1'b1;
            end else begin
              page_q <= page_q + 1'b1;
              st_q   <= W_PAGE_SEL;
            end
          end
        end
        W_FINAL:   st_q <= W_FINAL;
        W_INVALID: st_q <= W_INVALID;
        default:   st_q <= W_INVALID;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      W_ERASE: cmd_op = OP_ERASE;
      W_PROG:  cmd_op = OP_PROG;
      default: cmd_op = OP_READ;
    endcase
  end

  assign sw_allow  = (st_q == W_IDLE) && !wipe_req;
  assign owns      = owns_engine(st_q);
  assign cmd_valid = is_step(st_q) && !issued_q;
  assign cmd_page  = page_q;
  assign ack       = ack_q;
  assign fatal     = fatal_q;

endmodule

// File: rtl/wipe_arb_mux.sv
module wipe_arb_mux #(
  parameter int PAGE_W = 4
) (
  input  logic              wipe_owns,
  input  logic              sw_busy,
  input  logic              sw_valid,
  input  logic [1:0]        sw_op,
  input  logic [PAGE_W-1:0] sw_page,
  input  logic              wp_valid,
  input  logic [1:0]        wp_op,
  input  logic [PAGE_W-1:0] wp_page,
  input  logic              eng_cmd_ready,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              eng_cmd_valid,
  output logic [1:0]        eng_op,
  output logic [PAGE_W-1:0] eng_page,
  output logic              sw_ready,
  output logic              wp_ready,
  output logic              sw_done,
  output logic              sw_err,
  output logic              wp_done,
  output logic              wp_err
);

  always_comb begin
    if (wipe_owns) begin
      eng_cmd_valid = wp_valid;
      eng_op        = wp_op;
      eng_page      = wp_page;
    end else begin
      eng_cmd_valid = sw_valid;
      eng_op        = sw_op;
      eng_page      = sw_page;
    end
  end

  assign sw_ready = !wipe_owns && eng_cmd_ready;
  assign wp_ready = wipe_owns && eng_cmd_ready;
  assign sw_done  = sw_busy && eng_done;
  assign sw_err   = sw_busy && eng_done && eng_err;
  assign wp_done  = wipe_owns && eng_done;
  assign wp_err   = wipe_owns && eng_err;

endmodule

// File: rtl/wipe_arb.sv
module wipe_arb #(
  parameter int TOTAL_PAGES = 16,
  parameter int WIPE_PAGES  = 4,
  parameter int PAGE_W      = $clog2(TOTAL_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req,
  input  logic [1:0]        sw_op,
  input  logic [PAGE_W-1:0] sw_page,
  output logic              sw_gnt,
  output logic              sw_done,
  output logic              sw_err,
  input  logic              wipe_req,
  output logic              wipe_ack,
  output logic              wipe_busy,
  output logic              fatal_err,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_op,
  output logic [PAGE_W-1:0] eng_page,
  input  logic              eng_done,
  input  logic              eng_err
);

  logic              allow_sw, wipe_owns, sw_busy;
  logic              sw_valid, sw_ready, wp_valid, wp_ready;
  logic              wp_done, wp_err;
  logic [1:0]        sw_cmd_op, wp_cmd_op;
  logic [PAGE_W-1:0] sw_cmd_page, wp_cmd_page;

  wipe_arb_sw #(.PAGE_W(PAGE_W)) u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_req    (sw_req),
    .sw_op     (sw_op),
    .sw_page   (sw_page),
    .allow     (allow_sw),
    .cmd_ready (sw_ready),
    .done      (sw_done),
    .gnt       (sw_gnt),
    .busy      (sw_busy),
    .cmd_valid (sw_valid),
    .cmd_op    (sw_cmd_op),
    .cmd_page  (sw_cmd_page)
  );

  wipe_arb_seq #(.WIPE_PAGES(WIPE_PAGES), .PAGE_W(PAGE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wipe_req  (wipe_req),
    .sw_busy   (sw_busy),
    .cmd_ready (wp_ready),
    .done      (wp_done),
    .err       (wp_err),
    .sw_allow  (allow_sw),
    .owns      (wipe_owns),
    .cmd_valid (wp_valid),
    .cmd_op    (wp_cmd_op),
    .cmd_page  (wp_cmd_page),
    .ack       (wipe_ack),
    .fatal     (fatal_err)
  );

  wipe_arb_mux #(.PAGE_W(PAGE_W)) u_mux (
    .wipe_owns     (wipe_owns),
    .sw_busy       (sw_busy),
    .sw_valid      (sw_valid),
    .sw_op         (sw_cmd_op),
    .sw_page       (sw_cmd_page),
    .wp_valid      (wp_valid),
    .wp_op         (wp_cmd_op),
    .wp_page       (wp_cmd_page),
    .eng_cmd_ready (eng_cmd_ready),
    .eng_done      (eng_done),
    .eng_err       (eng_err),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_op        (eng_op),
    .eng_page      (eng_page),
    .sw_ready      (sw_ready),
    .wp_ready      (wp_ready),
    .sw_done       (sw_done),
    .sw_err        (sw_err),
    .wp_done       (wp_done),
    .wp_err        (wp_err)
  );

  assign wipe_busy = wipe_owns;

endmodule

// File: rtl/wipe_arb_chk.sv
module wipe_arb_chk #(
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_gnt,
  input logic              sw_done,
  input logic              wipe_req,
  input logic              wipe_ack,
  input logic              wipe_busy,
  input logic              fatal_err,
  input logic              eng_cmd_valid,
  input logic              eng_cmd_ready,
  input logic [1:0]        eng_op,
  input logic [PAGE_W-1:0] eng_page
);

  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else if (wipe_ack || fatal_err) locked_q <= 1'b1;
  end

  a_r2_gnt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gnt |=> !sw_gnt);

  a_r2_gnt_issues: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gnt |-> eng_cmd_valid);

  a_r3_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_cmd_ready) |=> (eng_cmd_valid && $stable(eng_op) && $stable(eng_page)));

  a_r4_done_not_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> !wipe_busy);

  a_r5_gnt_not_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gnt |-> !wipe_busy);

  a_r6_op_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && wipe_busy) |-> (eng_op != 2'd3));

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_ack |=> !wipe_ack);

  a_r8_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> (!sw_gnt && !eng_cmd_valid));

  a_r9_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err);

  a_r9_no_ack_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> !wipe_ack);

  a_r10_wipe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_req |=> !sw_gnt);

endmodule

bind wipe_arb wipe_arb_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_gnt        (sw_gnt),
  .sw_done       (sw_done),
  .wipe_req      (wipe_req),
  .wipe_ack      (wipe_ack),
  .wipe_busy     (wipe_busy),
  .fatal_err     (fatal_err),
  .eng_cmd_valid (eng_cmd_valid),
  .eng_cmd_ready (eng_cmd_ready),
  .eng_op        (eng_op),
  .eng_page      (eng_page)
);

// File: tb/wipe_arb_tb_top.sv
`timescale 1ns/1ps
module wipe_arb_tb_top;

  localparam int TP = 8;
  localparam int WP = 3;
  localparam int PW = 3;
  localparam int NV = 6;
  // op, page, latency, ready stall, inject error
  localparam int VEC [NV][5] = '{
    '{0, 5, 1, 0, 0},
    '{1, 7, 3, 0, 0},
    '{2, 0, 2, 2, 0},
    '{0, 3, 5, 3, 1},
    '{1, 1, 1, 1, 1},
    '{2, 6, 4, 0, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_req = 1'b0;
  logic [1:0]    sw_op = '0;
  logic [PW-1:0] sw_page = '0;
  logic          sw_gnt, sw_done, sw_err;
  logic          wipe_req = 1'b0;
  logic          wipe_ack, wipe_busy, fatal_err;
  logic          eng_cmd_valid, eng_cmd_ready;
  logic [1:0]    eng_op;
  logic [PW-1:0] eng_page;
  logic          eng_done, eng_err;

  int checks = 0;
  int failures = 0;

  // engine stub state
  int   stub_lat = 2;
  int   stub_stall = 0;
  bit   inj_now = 1'b0;
  int   err_at = -1;
  int   cmd_n = 0;
  int   wait_cnt = 0;
  int   cnt = 0;
  bit   busy = 1'b0;
  bit   cur_err = 1'b0;
  logic [1:0]    log_op [64];
  logic [PW-1:0] log_page [64];

  always #2 clk = ~clk;

  wipe_arb #(.TOTAL_PAGES(TP), .WIPE_PAGES(WP), .PAGE_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sw_req(sw_req), .sw_op(sw_op), .sw_page(sw_page),
    .sw_gnt(sw_gnt), .sw_done(sw_done), .sw_err(sw_err),
    .wipe_req(wipe_req), .wipe_ack(wipe_ack), .wipe_busy(wipe_busy), .fatal_err(fatal_err),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_op(eng_op), .eng_page(eng_page),
    .eng_done(eng_done), .eng_err(eng_err)
  );

  assign eng_cmd_ready = !busy && (wait_cnt >= stub_stall);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= 0;
      wait_cnt <= 0;
      eng_done <= 1'b0;
      eng_err  <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      eng_err  <= 1'b0;
      if (eng_cmd_valid && eng_cmd_ready) begin
        if (cmd_n < 64) begin
          log_op[cmd_n]   <= eng_op;
          log_page[cmd_n] <= eng_page;
        end
        cur_err  <= inj_now || (cmd_n == err_at);
        cmd_n    <= cmd_n + 1;
        busy     <= 1'b1;
        cnt      <= stub_lat;
        wait_cnt <= 0;
      end else if (eng_cmd_valid) begin
        wait_cnt <= wait_cnt + 1;
      end
      if (busy) begin
        if (cnt <= 1) begin
          busy     <= 1'b0;
          eng_done <= 1'b1;
          eng_err  <= cur_err;
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle_outputs(input string req);
    check(!sw_gnt && !sw_done && !wipe_ack && !wipe_busy && !fatal_err && !eng_cmd_valid, req,
          {sw_gnt, sw_done, wipe_ack, wipe_busy, fatal_err, eng_cmd_valid}, 0);
  endtask

  task automatic apply_reset();
    @(negedge clk) rst_n = 1'b0;
    sw_req = 1'b0;
    wipe_req = 1'b0;
    inj_now = 1'b0;
    err_at = -1;
    repeat (3) @(negedge clk);
    check_idle_outputs("R1");
    rst_n = 1'b1;
  endtask

  task automatic sw_vec(input int op, input int page, input int lat, input int stall, input int err);
    bit seen;
    stub_lat = lat;
    stub_stall = stall;
    inj_now = err[0];
    @(negedge clk);
    sw_req = 1'b1;
    sw_op = op[1:0];
    sw_page = page[PW-1:0];
    @(negedge clk);
    check(sw_gnt === 1'b1, "R2 grant", sw_gnt, 1);
    check(eng_cmd_valid && eng_op == op[1:0] && eng_page == page[PW-1:0], "R2 command",
          {eng_cmd_valid, eng_op, eng_page}, {1'b1, op[1:0], page[PW-1:0]});
    sw_req = 1'b0;
    for (int i = 0; i < stall; i++) begin
      check(eng_cmd_valid && !eng_cmd_ready && eng_op == op[1:0] && eng_page == page[PW-1:0],
            "R3 hold", {eng_cmd_valid, eng_op, eng_page}, {1'b1, op[1:0], page[PW-1:0]});
      @(negedge clk);
    end
    seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      if (sw_done) seen = 1'b1;
      else @(negedge clk);
    end
    check(seen, "R4 done", seen, 1);
    check(sw_err == err[0], "R4 error", sw_err, err);
    inj_now = 1'b0;
    stub_stall = 0;
    @(negedge clk);
  endtask

  task automatic wait_wipe_end(output bit got_ack);
    bit fin;
    got_ack = 1'b0;
    fin = 1'b0;
    for (int i = 0; i < 2000 && !fin; i++) begin
      @(negedge clk);
      if (wipe_ack) begin
        got_ack = 1'b1;
        fin = 1'b1;
        @(negedge clk);
        check(!wipe_ack, "R7 ack one cycle", wipe_ack, 0);
        check(!wipe_busy, "R7 busy low after ack", wipe_busy, 0);
      end else if (fatal_err) begin
        fin = 1'b1;
      end
    end
  endtask

  task automatic check_wipe_log(input int base, input int n, input string req);
    int bad;
    bad = 0;
    for (int k = 0; k < n; k++) begin
      int expop;
      expop = (k % 3 == 0) ? 2 : ((k % 3 == 1) ? 1 : 0);
      if (log_op[base + k] != expop[1:0] || log_page[base + k] != PW'(k / 3)) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic check_lockout(input string req);
    int n0;
    bit bad;
    n0 = cmd_n;
    bad = 1'b0;
    @(negedge clk) sw_req = 1'b1;
    sw_op = 2'd1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sw_gnt || eng_cmd_valid) bad = 1'b1;
    end
    sw_req = 1'b0;
    check(!bad && cmd_n == n0, req, cmd_n - n0, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    int base;
    // R1: reset state
    #1;
    check_idle_outputs("R1");
    repeat (3) @(negedge clk);
    check_idle_outputs("R1");
    rst_n = 1'b1;

    // R2, R3, R4: table of software operations
    for (int v = 0; v < NV; v++) begin
      sw_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
    end

    // R10: wipe and software requested together in first cycle after reset
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_idle_outputs("R1");
    stub_lat = 3;
    base = cmd_n;
    rst_n = 1'b1;
    wipe_req = 1'b1;
    sw_req = 1'b1;
    sw_op = 2'd0;
    @(negedge clk);
    check(!sw_gnt, "R10 wipe wins", sw_gnt, 0);
    wipe_req = 1'b0;
    sw_req = 1'b0;
    for (int i = 0; i < 200 && cmd_n < base + 2; i++) @(negedge clk);
    check_wipe_log(base, 2, "R10 wipe started");
    // R11: reset in the middle of the wipe
    rst_n = 1'b0;
    #1;
    check_idle_outputs("R11");
    @(negedge clk);
    rst_n = 1'b1;
    sw_vec(2, 4, 2, 1, 0);
    base = cmd_n;
    @(negedge clk) wipe_req = 1'b1;
    @(negedge clk) wipe_req = 1'b0;
    wait_wipe_end(ack);
    check(ack, "R11 wipe after reset", ack, 1);
    check_wipe_log(base, 3 * WP, "R11 sequence");

    // R5, R12: single-cycle wipe pulse during an outstanding software op
    apply_reset();
    stub_lat = 15;
    base = cmd_n;
    @(negedge clk) sw_req = 1'b1;
    sw_op = 2'd0;
    sw_page = 3'd7;
    @(negedge clk);
    check(sw_gnt, "R2 grant before wipe", sw_gnt, 1);
    sw_req = 1'b0;
    wipe_req = 1'b1;
    @(negedge clk) wipe_req = 1'b0;
    for (int i = 0; i < 100 && !sw_done; i++) @(negedge clk);
    check(sw_done && cmd_n == base + 1, "R5 drain", cmd_n - base, 1);
    stub_lat = 2;
    stub_stall = 2;
    repeat (6) @(negedge clk);
    check(wipe_busy, "R7 busy during wipe", wipe_busy, 1);
    wait_wipe_end(ack);
    check(ack, "R12 pulse honoured", ack, 1);
    check_wipe_log(base + 1, 3 * WP, "R6 sequence");
    check(cmd_n == base + 1 + 3 * WP, "R6 command count", cmd_n - base, 1 + 3 * WP);
    stub_stall = 0;
    check_lockout("R8 after clean wipe");
    check(!fatal_err, "R9 no fatal on clean wipe", fatal_err, 0);

    // R9: engine error on page 1 program step
    apply_reset();
    stub_lat = 2;
    base = cmd_n;
    err_at = base + 4;
    @(negedge clk) wipe_req = 1'b1;
    @(negedge clk) wipe_req = 1'b0;
    wait_wipe_end(ack);
    check(!ack, "R9 no ack", ack, 0);
    check(fatal_err, "R9 fatal raised", fatal_err, 1);
    repeat (20) @(negedge clk);
    check(cmd_n == base + 5, "R9 no further command", cmd_n - base, 5);
    check(fatal_err && !wipe_busy, "R9 fatal sticky", {fatal_err, wipe_busy}, 2);
    check_lockout("R8 after failed wipe");
    err_at = -1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule